// File: doc/BRIEF.md
# Multi-channel DAC command register controller

This block holds the digital state of an eight-channel converter whose channels each combine a 10-bit main code and an 8-bit sub (fine offset) code. Command words of 16 bits arrive already assembled, each marked by a one-cycle valid strobe. Two mode bits in the word pick one of four targets: the global system control register, the control register of one addressed channel, or that channel's main or sub data register.

Every channel keeps a data register and a DAC register for both its main and sub codes. Writes land in the data registers only. The active-low load input copies all data registers into their DAC registers together, and the DAC registers drive the output codes. A hardware clear input, a global software clear, and per-channel clears that take effect on the next load bring the codes to known values. Standby, power-down, coding and reference-select flags are kept and brought out for the analog side.

Top module: `dac_reg_ctrl`

## Requirements
- R1: On synchronous reset (rst_n low at a clock edge) the block applies its defaults: twos complement coding (offset_bin=0), pwr_on=1, sys_stby=1, and for every channel ch_normal=1, ch_ref=00, a per-channel clear armed, and all main and sub data and DAC codes at 0.
- R2: A word with cmd_valid high is decoded from bit 14 (MD0) and bit 13 (MD1): MD1=0/MD0=0 targets system control, MD1=0/MD0=1 targets the control register of the channel at bits 12..10, and MD1=1 targets that channel's data register whatever MD0 is, with bit 15 choosing main (0) or sub (1).
- R3: A system control write sets offset_bin from bit 6 (1 = offset binary), pwr_on from bit 5 (1 = normal, 0 = power down) and sys_stby from bit 4 (1 = standby); the address bits have no effect.
- R4: A channel control write updates only the addressed channel: ch_ref from bits 9..8, ch_normal from bit 4 (0 = standby), and the clear-arm flag from bit 3.
- R5: A main data write stores bits 9..0 and a sub data write stores bits 9..2 (bits 1..0 ignored) into the addressed channel's data register; the output codes do not change until a load.
- R6: On every clock edge where load_n is low, all channels copy their main and sub data registers into their DAC registers at once; while load_n is high and no clear is active the DAC codes hold.
- R7: On every clock edge where hw_clr_n is low, all main data and DAC codes become 0 and all sub data and DAC codes become 0x80 under offset binary or 0x00 under twos complement (the coding in effect before that edge); this overrides every other update of those registers.
- R8: A system control write with bit 3 set clears the main data and DAC codes of all channels on that edge and leaves every sub code unchanged.
- R9: A load on a channel whose clear-arm flag was already set before that edge sets its main data and DAC codes to 0 instead of copying; setting the flag alone changes no output code.
- R10: ch_live[i] is 1 exactly when pwr_on is 1, sys_stby is 0 and ch_normal[i] is 1.
- R11: A word presented with cmd_valid low changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset to defaults |
| cmd_valid | input | 1 | One-cycle strobe marking cmd_word valid |
| cmd_word | input | 16 | Command word |
| load_n | input | 1 | Active-low load of all DAC registers from data registers |
| hw_clr_n | input | 1 | Active-low hardware clear |
| main_code | output | NCH*10 | Main DAC register codes, channel i at bits i*10 +: 10 |
| sub_code | output | NCH*8 | Sub DAC register codes, channel i at bits i*8 +: 8 |
| ch_ref | output | NCH*2 | Reference select per channel, channel i at bits i*2 +: 2 |
| ch_normal | output | NCH | Per-channel normal (1) or standby (0) flag |
| ch_live | output | NCH | Channel active: powered, not in system standby, channel normal |
| offset_bin | output | 1 | Coding: 1 offset binary, 0 twos complement |
| pwr_on | output | 1 | 1 normal operation, 0 power down |
| sys_stby | output | 1 | 1 all channels in system standby |

## Verification
The assertions take load_n and hw_clr_n to be sampled levels that may sit low for any number of cycles and may coincide with a command word, and they take the coding flag seen at a hardware clear to be the one held before that edge. The stimulus drives every input on the falling edge and mixes random words, loads and clears, including loads and clears in the same cycle as writes, so the override order of R7, R8 and R9 is exercised. Hardware clear is kept rare so that loaded data survives long enough to be seen at the outputs.

// File: rtl/dacr_pkg.sv
package dacr_pkg;
    localparam int WORD_W  = 16;
    localparam int MAIN_W  = 10;
    localparam int SUB_W   = 8;
    localparam int REF_W   = 2;
    localparam logic [SUB_W-1:0] SUB_ZERO_OB = 8'h80;

    typedef struct packed {
        logic sys_we;
        logic ctl_we;
        logic main_we;
        logic sub_we;
    } strobe_t;

    typedef struct packed {
        logic              coding;
        logic              pd_n;
        logic              sstby;
    } sys_t;

    typedef struct packed {
        logic [MAIN_W-1:0] main_dat;
        logic [MAIN_W-1:0] main_dac;
        logic [SUB_W-1:0]  sub_dat;
        logic [SUB_W-1:0]  sub_dac;
        logic [REF_W-1:0]  refsel;
        logic              normal;
        logic              clr_arm;
    } chan_t;
endpackage

// File: rtl/dacr_decode.sv
module dacr_decode
    import dacr_pkg::*;
(
    input  logic       valid,
    input  logic [2:0] mode,
    output strobe_t    stb
);
    // mode = {bit15 sub, bit14 MD0, bit13 MD1}
    always_comb begin
        stb = '0;
        if (valid) begin
            if (mode[0]) begin
                stb.main_we = ~mode[2];
                stb.sub_we  =  mode[2];
            end else if (mode[1]) begin
                stb.ctl_we  = 1'b1;
            end else begin
                stb.sys_we  = 1'b1;
            end
        end
    end

    always_comb begin
        a_r2_one_target: assert ($onehot0(stb));
    end
endmodule

// File: rtl/dacr_channel.sv
module dacr_channel
    import dacr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_clr,
    input  logic              off_bin,
    input  logic              sclr,
    input  logic              load,
    input  logic              ctl_we,
    input  logic              main_we,
    input  logic              sub_we,
    input  logic [MAIN_W-1:0] wdata,
    input  logic [1:0]        ctl_bits,
    output logic [MAIN_W-1:0] main_code,
    output logic [SUB_W-1:0]  sub_code,
    output logic [REF_W-1:0]  refsel,
    output logic              normal
);
    localparam chan_t RST_VAL = '{main_dat: '0, main_dac: '0, sub_dat: '0,
                                  sub_dac: '0, refsel: '0, normal: 1'b1,
                                  clr_arm: 1'b1};

    chan_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        if (ctl_we) begin
            ch_d.refsel  = wdata[9:8];
            ch_d.normal  = ctl_bits[1];
            ch_d.clr_arm = ctl_bits[0];
        end
        if (main_we) ch_d.main_dat = wdata;
        if (sub_we)  ch_d.sub_dat  = wdata[MAIN_W-1 -: SUB_W];
        if (load) begin
            ch_d.main_dac = ch_q.main_dat;
            ch_d.sub_dac  = ch_q.sub_dat;
            if (ch_q.clr_arm) begin
                ch_d.main_dat = '0;
                ch_d.main_dac = '0;
            end
        end
        if (sclr) begin
            ch_d.main_dat = '0;
            ch_d.main_dac = '0;
        end
        if (hw_clr) begin
            ch_d.main_dat = '0;
            ch_d.main_dac = '0;
            ch_d.sub_dat  = off_bin ? SUB_ZERO_OB : '0;
            ch_d.sub_dac  = off_bin ? SUB_ZERO_OB : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ch_q <= RST_VAL;
        else        ch_q <= ch_d;
    end

    assign main_code = ch_q.main_dac;
    assign sub_code  = ch_q.sub_dac;
    assign refsel    = ch_q.refsel;
    assign normal    = ch_q.normal;

    a_r7_hw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        hw_clr |=> (main_code == '0) &&
                   (sub_code == ($past(off_bin) ? SUB_ZERO_OB : '0)));

    a_r6_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !hw_clr && !sclr) |=> $stable(main_code) && $stable(sub_code));

    a_r8_sclr_main_only: assert property (@(posedge clk) disable iff (!rst_n)
        (sclr && !hw_clr && !load) |=> (main_code == '0) && $stable(sub_code));

    a_r9_armed_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (load && ch_q.clr_arm) |=> (main_code == '0));
endmodule

// File: rtl/dac_reg_ctrl.sv
module dac_reg_ctrl
    import dacr_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic [WORD_W-1:0]     cmd_word,
    input  logic                  load_n,
    input  logic                  hw_clr_n,
    output logic [NCH*MAIN_W-1:0] main_code,
    output logic [NCH*SUB_W-1:0]  sub_code,
    output logic [NCH*REF_W-1:0]  ch_ref,
    output logic [NCH-1:0]        ch_normal,
    output logic [NCH-1:0]        ch_live,
    output logic                  offset_bin,
    output logic                  pwr_on,
    output logic                  sys_stby
);
    localparam int AW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam sys_t SYS_RST = '{coding: 1'b0, pd_n: 1'b1, sstby: 1'b1};

    strobe_t stb;
    sys_t    sys_d, sys_q;
    logic    sclr;
    logic [AW-1:0] addr;

    dacr_decode u_dec (
        .valid (cmd_valid),
        .mode  (cmd_word[15:13]),
        .stb   (stb)
    );

    assign addr = cmd_word[10 +: AW];
    assign sclr = stb.sys_we & cmd_word[3];

    always_comb begin
        sys_d = sys_q;
        if (stb.sys_we) begin
            sys_d.coding = cmd_word[6];
            sys_d.pd_n   = cmd_word[5];
            sys_d.sstby  = cmd_word[4];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sys_q <= SYS_RST;
        else        sys_q <= sys_d;
    end

    assign offset_bin = sys_q.coding;
    assign pwr_on     = sys_q.pd_n;
    assign sys_stby   = sys_q.sstby;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit;
        assign hit = (addr == AW'(i));

        dacr_channel u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .hw_clr    (~hw_clr_n),
            .off_bin   (sys_q.coding),
            .sclr      (sclr),
            .load      (~load_n),
            .ctl_we    (stb.ctl_we & hit),
            .main_we   (stb.main_we & hit),
            .sub_we    (stb.sub_we & hit),
            .wdata     (cmd_word[MAIN_W-1:0]),
            .ctl_bits  (cmd_word[4:3]),
            .main_code (main_code[i*MAIN_W +: MAIN_W]),
            .sub_code  (sub_code[i*SUB_W +: SUB_W]),
            .refsel    (ch_ref[i*REF_W +: REF_W]),
            .normal    (ch_normal[i])
        );

        assign ch_live[i] = sys_q.pd_n & ~sys_q.sstby & ch_normal[i];
    end

    a_r11_sys_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_word[14:13] == 2'b00) |=>
            $stable(offset_bin) && $stable(pwr_on) && $stable(sys_stby));

    a_r4_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_word[14:13] == 2'b10) |=>
            $stable(ch_ref) && $stable(ch_normal));
endmodule

// File: tb/sim_dac_reg_ctrl.sv
`timescale 1ns/100ps
module sim_dac_reg_ctrl;
    localparam int NCH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic load_n = 1'b1;
    logic hw_clr_n = 1'b1;
    logic [NCH*10-1:0] main_code;
    logic [NCH*8-1:0]  sub_code;
    logic [NCH*2-1:0]  ch_ref;
    logic [NCH-1:0]    ch_normal, ch_live;
    logic offset_bin, pwr_on, sys_stby;

    int n_checks = 0;
    int n_errors = 0;

    // expected state
    logic [9:0] e_md [NCH];
    logic [9:0] e_mr [NCH];
    logic [7:0] e_sd [NCH];
    logic [7:0] e_sr [NCH];
    logic [1:0] e_ref [NCH];
    logic       e_nrm [NCH];
    logic       e_arm [NCH];
    logic e_cod, e_pd, e_sst;

    always #2.5 clk = ~clk;

    dac_reg_ctrl #(.NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .load_n(load_n), .hw_clr_n(hw_clr_n), .main_code(main_code),
        .sub_code(sub_code), .ch_ref(ch_ref), .ch_normal(ch_normal),
        .ch_live(ch_live), .offset_bin(offset_bin), .pwr_on(pwr_on),
        .sys_stby(sys_stby)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        summary();
    end

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin
            e_md[i] = '0; e_mr[i] = '0; e_sd[i] = '0; e_sr[i] = '0;
            e_ref[i] = '0; e_nrm[i] = 1'b1; e_arm[i] = 1'b1;
        end
        e_cod = 1'b0; e_pd = 1'b1; e_sst = 1'b1;
    endtask

    // expected update for one edge, from the requirements
    task automatic model_step(logic [15:0] w, bit v, bit ld, bit hc);
        bit sys_w, ctl_w, main_w, sub_w, sclr;
        int a;
        logic old_cod;
        old_cod = e_cod;
        sys_w  = v && !w[13] && !w[14];          // R2
        ctl_w  = v && !w[13] &&  w[14];
        main_w = v &&  w[13] && !w[15];
        sub_w  = v &&  w[13] &&  w[15];
        a      = int'(w[12:10]);
        sclr   = sys_w && w[3];                  // R8
        for (int i = 0; i < NCH; i++) begin
            logic old_arm;
            logic [9:0] md, mr;
            logic [7:0] sd, sr;
            old_arm = e_arm[i];
            md = e_md[i]; mr = e_mr[i]; sd = e_sd[i]; sr = e_sr[i];
            if (ctl_w && a == i) begin           // R4
                e_ref[i] = w[9:8]; e_nrm[i] = w[4]; e_arm[i] = w[3];
            end
            if (main_w && a == i) md = w[9:0];   // R5
            if (sub_w && a == i)  sd = w[9:2];
            if (ld) begin                        // R6, R9
                mr = e_md[i]; sr = e_sd[i];
                if (old_arm) begin md = '0; mr = '0; end
            end
            if (sclr) begin md = '0; mr = '0; end
            if (hc) begin                        // R7
                md = '0; mr = '0;
                sd = old_cod ? 8'h80 : 8'h00;
                sr = sd;
            end
            e_md[i] = md; e_mr[i] = mr; e_sd[i] = sd; e_sr[i] = sr;
        end
        if (sys_w) begin                         // R3
            e_cod = w[6]; e_pd = w[5]; e_sst = w[4];
        end
    endtask

    task automatic apply(logic [15:0] w, bit v, bit ld, bit hc);
        @(negedge clk);
        cmd_word = w; cmd_valid = v; load_n = !ld; hw_clr_n = !hc;
        @(posedge clk);
        model_step(w, v, ld, hc);
        #1;
    endtask

    task automatic idle();
        apply(16'h0000, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic check_all(string req);
        chk({req, " offset_bin"}, int'(offset_bin), int'(e_cod));
        chk({req, " pwr_on"},     int'(pwr_on),     int'(e_pd));
        chk({req, " sys_stby"},   int'(sys_stby),   int'(e_sst));
        for (int i = 0; i < NCH; i++) begin
            chk({req, " main_code"}, int'(main_code[i*10 +: 10]), int'(e_mr[i]));
            chk({req, " sub_code"},  int'(sub_code[i*8 +: 8]),    int'(e_sr[i]));
            chk({req, " ch_ref"},    int'(ch_ref[i*2 +: 2]),      int'(e_ref[i]));
            chk({req, " ch_normal"}, int'(ch_normal[i]),          int'(e_nrm[i]));
            chk({req, " R10 ch_live"}, int'(ch_live[i]),
                int'(e_pd && !e_sst && e_nrm[i]));
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        check_all("R1 reset");
        chk("R1 reset main A", int'(main_code[9:0]), 0);

        // R3: leave standby, offset binary; address bits set to show they are ignored
        apply(16'h1C60, 1'b1, 1'b0, 1'b0);
        chk("R3 offset_bin", int'(offset_bin), 1);
        chk("R3 sys_stby", int'(sys_stby), 0);
        check_all("R3");

        // R4: channel A normal, internal reference, clear disarmed
        apply(16'h4110, 1'b1, 1'b0, 1'b0);
        chk("R4 ref A", int'(ch_ref[1:0]), 1);
        chk("R4 ref B untouched", int'(ch_ref[3:2]), 0);
        check_all("R4");

        // R5: main A half scale, not yet visible
        apply(16'h2200, 1'b1, 1'b0, 1'b0);
        chk("R5 main A before load", int'(main_code[9:0]), 0);
        // sub A with low bits set: bits 1..0 ignored
        apply(16'hA203, 1'b1, 1'b0, 1'b0);
        chk("R5 sub A before load", int'(sub_code[7:0]), 0);
        // R6: load copies all
        apply(16'h0000, 1'b0, 1'b1, 1'b0);
        chk("R6 main A after load", int'(main_code[9:0]), 10'h200);
        chk("R6 sub A after load", int'(sub_code[7:0]), 8'h80);
        check_all("R6");

        // R9: channel B still armed, load gives 0
        apply(16'h2555, 1'b1, 1'b0, 1'b0);
        apply(16'h0000, 1'b0, 1'b1, 1'b0);
        chk("R9 armed B cleared", int'(main_code[19:10]), 0);
        apply(16'h4410, 1'b1, 1'b0, 1'b0);
        apply(16'h2555, 1'b1, 1'b0, 1'b0);
        apply(16'h0000, 1'b0, 1'b1, 1'b0);
        chk("R9 disarmed B loads", int'(main_code[19:10]), 10'h155);
        // arming A alone changes nothing
        apply(16'h4118, 1'b1, 1'b0, 1'b0);
        chk("R9 arm without load", int'(main_code[9:0]), 10'h200);
        apply(16'h0000, 1'b0, 1'b1, 1'b0);
        chk("R9 armed A on load", int'(main_code[9:0]), 0);
        check_all("R9");

        // R11: valid low word would power down
        apply(16'h0000, 1'b0, 1'b0, 1'b0);
        chk("R11 ignored word", int'(pwr_on), 1);

        // R8: system clear keeps sub codes
        apply(16'h0068, 1'b1, 1'b0, 1'b0);
        chk("R8 main B cleared", int'(main_code[19:10]), 0);
        chk("R8 sub A kept", int'(sub_code[7:0]), 8'h80);
        check_all("R8");

        // R2: MD0 set with MD1 set still a main data write
        apply(16'h63FF, 1'b1, 1'b0, 1'b0);
        apply(16'h4110, 1'b1, 1'b0, 1'b0);
        apply(16'h63FF, 1'b1, 1'b0, 1'b0);
        apply(16'h0000, 1'b0, 1'b1, 1'b0);
        chk("R2 MD0 dont care", int'(main_code[9:0]), 10'h3FF);

        // R7: hardware clear under offset binary, then twos complement
        apply(16'hBC44, 1'b1, 1'b0, 1'b1);
        chk("R7 sub H offset binary", int'(sub_code[63:56]), 8'h80);
        chk("R7 main A", int'(main_code[9:0]), 0);
        apply(16'h0020, 1'b1, 1'b0, 1'b0);
        apply(16'h0000, 1'b0, 1'b1, 1'b1);
        chk("R7 sub A twos", int'(sub_code[7:0]), 8'h00);
        check_all("R7");

        // mid-run reset
        apply(16'h0000, 1'b0, 1'b0, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); model_reset(); #1;
        @(negedge clk); rst_n = 1'b1;
        #1;
        check_all("R1 reset again");

        // random phase
        for (int k = 0; k < 3000; k++) begin
            logic [15:0] w;
            bit v, ld, hc;
            w  = 16'($urandom);
            v  = ($urandom % 2) == 0;
            ld = ($urandom % 4) == 0;
            hc = ($urandom % 40) == 0;
            apply(w, v, ld, hc);
            check_all("R2 random");
        end
        idle();
        check_all("R6 final");
        summary();
    end
endmodule